// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes written by a host into an asynchronous serial stream on one output line. A write strobe places a byte in a one-entry holding register. As soon as the shifter is idle, the byte moves into it and goes out as a start bit, then the data bits with the least significant bit first, then an optional parity bit and a stop period.

A 7-bit line-control word sets the framing at run time. It selects the word length (5 to 8 bits), the stop length (1, 1.5 or 2 bits), whether parity is sent, and the parity kind (odd, even, or fixed at one level). It also has a bit that holds the line at the break level. Bit timing comes from an external enable pulse at 16 times the bit rate, produced by a divisor counter that divides the reference clock by 16 times the bit rate.

Two flags report progress. One says the holding register can take a new byte. The other says that nothing is held and nothing is being shifted.

Top module: `ser_tx`

## Requirements
- R1: While reset is asserted and after it is released with no write, the line output is 1 and both empty flags are 1.
- R2: The idle line is 1. Each frame begins with exactly one start bit at level 0, followed by the data bits with bit 0 first.
- R3: Line-control bits [1:0] set the word length: code 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the word length are not sent.
- R4: Line-control bit 2 = 0 gives a stop period of 16 ticks. Bit 2 = 1 gives 32 ticks, or 24 ticks when the word length code is 00. The line is 1 during the stop period.
- R5: Line-control bit 3 = 1 adds a parity bit after the data bits. With bit 5 = 0, bit 4 = 1 gives even parity and bit 4 = 0 gives odd parity, counted over the sent data bits plus the parity bit. With bit 3 = 0 no parity bit is sent.
- R6: With bits 3 and 5 both set, the parity bit is fixed: it is 1 when bit 4 is 0 and 0 when bit 4 is 1.
- R7: While line-control bit 6 is 1, the line output is 0, whether a frame is in progress or not. The output returns to 1 when bit 6 clears and the line is idle.
- R8: The holding-empty flag reads 0 in the cycle after a write. It returns to 1 when the held byte moves into the shifter, and it stays 0 while a second byte waits behind a frame in progress.
- R9: The transmitter-empty flag is 1 only when the holding register and the shifter are both empty.
- R10: The start, data and parity bits each last 16 ticks of the rate enable. A frame lasts 16*(1 + word length + parity) ticks plus the stop period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Enable pulse at 16 times the bit rate |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Byte to send |
| line_ctrl_i | input | 7 | Framing control: [1:0] length, [2] stop, [3] parity on, [4] even, [5] fixed parity, [6] break |
| txd_o | output | 1 | Serial line output |
| thr_empty_o | output | 1 | Holding register empty |
| tx_empty_o | output | 1 | Holding register and shifter both empty |

## Verification
The assertions assume a few things about the inputs. Line-control bits 0 to 5 are not changed while a frame is being shifted; the framing is captured when a byte enters the shifter. A write only replaces a held byte when software means to overwrite it. The stimulus changes the framing only after the transmitter-empty flag is set. It writes only when the holding-empty flag is set, and it raises break only in a frame that it has taken out of the scoreboard. The rate enable is driven on alternate clocks, so one bit lasts 32 clocks, and the frame-length check allows a few clocks of tick-phase slack.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  localparam int DATA_W = 8;
  localparam int OVS    = 16;
  localparam int NB_W   = $clog2(DATA_W + 1);
  localparam int CNT_W  = $clog2(2 * OVS + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} tx_state_e;

  typedef struct packed {
    logic [NB_W-1:0]  nbits;
    logic             par_en;
    logic             par_bit;
    logic [CNT_W-1:0] stop_ticks;
  } frame_cfg_t;
endpackage

// File: rtl/tx_frame_decode.sv
module tx_frame_decode
  import ser_tx_pkg::*;
(
  input  logic [5:0]        lcr_i,
  input  logic [DATA_W-1:0] data_i,
  output frame_cfg_t        cfg_o
);
  logic [NB_W-1:0]   nbits;
  logic [DATA_W-1:0] mask;
  logic              xor_d;

  assign nbits = NB_W'(5) + NB_W'(lcr_i[1:0]);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (NB_W'(i) < nbits);
  end

  assign xor_d = ^(data_i & mask);

  always_comb begin
    cfg_o.nbits  = nbits;
    cfg_o.par_en = lcr_i[3];
    if (lcr_i[5]) cfg_o.par_bit = ~lcr_i[4];
    else          cfg_o.par_bit = lcr_i[4] ? xor_d : ~xor_d;
    if (!lcr_i[2])               cfg_o.stop_ticks = CNT_W'(OVS);
    else if (lcr_i[1:0] == 2'b00) cfg_o.stop_ticks = CNT_W'(OVS + OVS / 2);
    else                          cfg_o.stop_ticks = CNT_W'(2 * OVS);
  end
endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg
  import ser_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (wr_i) begin
      // a write in the take cycle keeps the new byte held
      full_o <= 1'b1;
      data_o <= data_i;
    end else if (take_i) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
  import ser_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              avail_i,
  input  logic [DATA_W-1:0] data_i,
  input  frame_cfg_t        cfg_i,
  output logic              take_o,
  output logic              busy_o,
  output logic              line_o
);
  tx_state_e         state_q, state_nxt;
  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q, cnt_last;
  logic [NB_W-1:0]   bitn_q;
  frame_cfg_t        cfg_q;
  logic              bit_end;

  assign take_o   = (state_q == ST_IDLE) && avail_i;
  assign busy_o   = (state_q != ST_IDLE);
  assign cnt_last = (state_q == ST_STOP) ? cfg_q.stop_ticks - CNT_W'(1) : CNT_W'(OVS - 1);
  assign bit_end  = tick_i && (cnt_q == cnt_last);

  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      ST_IDLE:  state_nxt = avail_i ? ST_START : ST_IDLE;
      ST_START: state_nxt = ST_DATA;
      ST_DATA:  if (bitn_q == cfg_q.nbits - NB_W'(1))
                  state_nxt = cfg_q.par_en ? ST_PAR : ST_STOP;
      ST_PAR:   state_nxt = ST_STOP;
      ST_STOP:  state_nxt = ST_IDLE;
      default:  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
      bitn_q  <= '0;
      cfg_q   <= '0;
    end else if (state_q == ST_IDLE) begin
      if (avail_i) begin
        state_q <= state_nxt;
        shreg_q <= data_i;
        cfg_q   <= cfg_i;
        cnt_q   <= '0;
        bitn_q  <= '0;
      end
    end else if (tick_i) begin
      if (bit_end) begin
        cnt_q   <= '0;
        state_q <= state_nxt;
        if (state_q == ST_DATA) begin
          shreg_q <= shreg_q >> 1;
          bitn_q  <= bitn_q + NB_W'(1);
        end
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = shreg_q[0];
      ST_PAR:   line_o = cfg_q.par_bit;
      default:  line_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/ser_tx.sv
module ser_tx
  import ser_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [6:0]        line_ctrl_i,
  output logic              txd_o,
  output logic              thr_empty_o,
  output logic              tx_empty_o
);
  logic              hold_full, take, busy, line;
  logic [DATA_W-1:0] hold_data;
  frame_cfg_t        cfg;

  tx_hold_reg i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .data_i (wr_data_i),
    .take_i (take),
    .full_o (hold_full),
    .data_o (hold_data)
  );

  tx_frame_decode i_dec (
    .lcr_i  (line_ctrl_i[5:0]),
    .data_i (hold_data),
    .cfg_o  (cfg)
  );

  tx_serializer i_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick16_i),
    .avail_i (hold_full),
    .data_i  (hold_data),
    .cfg_i   (cfg),
    .take_o  (take),
    .busy_o  (busy),
    .line_o  (line)
  );

  assign txd_o       = line & ~line_ctrl_i[6];
  assign thr_empty_o = ~hold_full;
  assign tx_empty_o  = ~hold_full & ~busy;
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic [6:0] line_ctrl_i,
  input logic       txd_o,
  input logic       thr_empty_o,
  input logic       tx_empty_o
);
  // R2
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o && !line_ctrl_i[6] |-> txd_o);
  // R2
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(thr_empty_o) && !line_ctrl_i[6] |-> !txd_o);
  // R7
  break_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_ctrl_i[6] |-> !txd_o);
  // R8
  wr_fills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !thr_empty_o);
  // R9
  empty_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> thr_empty_o);
endmodule

bind ser_tx ser_tx_chk i_ser_tx_chk (.*);

// File: tb/test_ser_tx.sv
module test_ser_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [6:0] lcr = '0;
  logic       txd, thr_e, tx_e;

  int n_chk = 0, n_fail = 0;
  bit mon_en = 1'b1, mon_busy = 1'b0;

  typedef struct { logic [7:0] d; int n; logic pe; logic pv; int st; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(negedge clk) tick <= rst_n ? ~tick : 1'b0;

  ser_tx i_ser_tx (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .wr_i(wr), .wr_data_i(wdata),
    .line_ctrl_i(lcr), .txd_o(txd), .thr_empty_o(thr_e), .tx_empty_o(tx_e)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t mk_exp(logic [7:0] d, logic [5:0] lc);
    exp_t e;
    logic x;
    e.n  = 5 + lc[1:0];
    e.d  = d & 8'((1 << e.n) - 1);
    x    = ^e.d;
    e.pe = lc[3];
    e.pv = lc[5] ? ~lc[4] : (lc[4] ? x : ~x);
    e.st = !lc[2] ? 16 : (lc[1:0] == 2'b00 ? 24 : 32);
    return e;
  endfunction

  // driver: pushes the expected frame, then writes the byte
  task automatic send(logic [7:0] d, logic [5:0] lc, bit push);
    while (!thr_e) @(negedge clk);
    lcr[5:0] = lc;
    if (push) q.push_back(mk_exp(d, lc));
    wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    chk("R8 thr after write", thr_e, 1'b0);
    chk("R9 temt after write", tx_e, 1'b0);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(tx_e && q.size() == 0 && !mon_busy)) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor: decodes frames from the line and compares with the queue
  initial begin
    bit   prev = 1'b1, chained = 1'b0;
    exp_t e;
    logic [7:0] got;
    int   len, tot;
    forever begin
      if (!chained) @(negedge clk);
      if (mon_en && rst_n && !txd && (prev || chained)) begin
        chained = 1'b0;
        mon_busy = 1'b1;
        if (q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R2 unexpected frame act=1 exp=0");
        end else begin
          e = q.pop_front();
          repeat (16) @(negedge clk);
          chk("R2 start bit", txd, 1'b0);
          got = '0;
          for (int k = 0; k < e.n; k++) begin
            repeat (32) @(negedge clk);
            got[k] = txd;
          end
          chk("R3 data bits", got, e.d);
          len = 16 + 32 * e.n;
          if (e.pe) begin
            repeat (32) @(negedge clk);
            len += 32;
            chk("R5 R6 parity bit", txd, e.pv);
          end
          repeat (32) @(negedge clk);
          len += 32;
          chk("R4 stop level", txd, 1'b1);
          forever begin
            @(negedge clk);
            len++;
            if (tx_e) break;
            if (!txd) begin chained = 1'b1; break; end
          end
          tot = 2 * (16 * (1 + e.n + (e.pe ? 1 : 0)) + e.st);
          n_chk++;
          if (len < tot - 3 || len > tot + 3) begin
            n_fail++;
            $display("FAIL R4 R10 frame length act=%0d exp=%0d", len, tot);
          end
        end
        mon_busy = 1'b0;
      end
      prev = txd;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 txd in reset", txd, 1'b1);
    chk("R1 thr in reset", thr_e, 1'b1);
    chk("R1 temt in reset", tx_e, 1'b1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 txd after reset", txd, 1'b1);
    chk("R1 thr after reset", thr_e, 1'b1);
    chk("R1 temt after reset", tx_e, 1'b1);

    send(8'hA5, 6'b000011, 1'b1); wait_idle();  // 8 bits, no parity, 1 stop
    send(8'hF3, 6'b000100, 1'b1); wait_idle();  // R3 R4 5 bits, 1.5 stop
    send(8'h5B, 6'b011110, 1'b1); wait_idle();  // R5 7 bits even, 2 stop
    send(8'h2D, 6'b001001, 1'b1); wait_idle();  // R5 6 bits odd
    send(8'h00, 6'b101011, 1'b1); wait_idle();  // R6 fixed 1
    send(8'hFF, 6'b111011, 1'b1); wait_idle();  // R6 fixed 0
    chk("R2 idle line", txd, 1'b1);

    // R8 back to back through the holding register
    send(8'h3C, 6'b000111, 1'b1);
    @(negedge clk);
    chk("R8 thr after move", thr_e, 1'b1);
    chk("R9 temt while shifting", tx_e, 1'b0);
    send(8'hC3, 6'b000111, 1'b1);
    repeat (100) @(negedge clk);
    chk("R8 thr while waiting", thr_e, 1'b0);
    chk("R9 temt while waiting", tx_e, 1'b0);
    wait_idle();

    // R7 break during a frame and while idle
    mon_en = 1'b0;
    send(8'hFF, 6'b000011, 1'b0);
    repeat (100) @(negedge clk);
    lcr[6] = 1'b1;
    #1 chk("R7 break mid frame", txd, 1'b0);
    repeat (40) @(negedge clk);
    chk("R7 break held", txd, 1'b0);
    while (!tx_e) @(negedge clk);
    chk("R7 break idle", txd, 1'b0);
    lcr[6] = 1'b0;
    #1 chk("R7 release", txd, 1'b1);
    repeat (4) @(negedge clk);
    mon_en = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule